// File: doc/BRIEF.md
# DDR Write Burst Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM interface and turns a stream of simple requests into Write, Read and Precharge commands. Each request names an operation, a bank, a starting column, a burst-length code and an auto-precharge flag. The block holds off a request with a ready/stall handshake until the command is legal. It then puts the command on a registered command bus one cycle later.

For writes, the block also produces the data schedule as one data pair per clock (the 2n-prefetch unit), tagged with bank and column. A later write may follow an earlier one by exactly as many cycles as the earlier burst has pairs, which keeps the data continuous, or it may come sooner and cut the earlier burst short. Reads wait for a programmable write-to-read turnaround after the last write pair. Precharges wait for a programmable write recovery on their own bank. After a precharge, whether explicit or automatic, the bank is closed to all commands for a programmable row-precharge time.

Top module: `wrburst_seq`

## Requirements
- R1: After reset the command bus and the data-pair output are idle and every operation to every bank reports ready.
- R2: An accepted request with op code 0 (write), 1 (read) or 2 (precharge) appears on the command bus exactly one cycle after acceptance, with the same op code, bank, column and auto-precharge flag. Op code 3 is accepted at once and issues nothing.
- R3: Burst-length code 0, 1, 2 or 3 gives 1, 2, 4 or 4 data pairs. The pairs come one per cycle, starting the cycle after the write command, each tagged with the write's bank.
- R4: For pair k of a burst with N pairs and starting column C, the column is (C with its low log2(2N) bits cleared) OR ((C + 2k) mod 2N).
- R5: A write command cuts off any unfinished pairs of the previous burst, and its own first pair follows in the next cycle. A write placed N cycles after one of N pairs yields an unbroken pair stream.
- R6: A read is accepted no earlier than cfg_twtr+1 cycles after the cycle holding the last write pair, and never while write data is pending. With nothing else blocking, it is accepted exactly then.
- R7: A precharge to bank b waits until cfg_twr+1 cycles after the last pair written to b, and is accepted exactly then. Write data to other banks does not delay it.
- R8: After a precharge to bank b is accepted in cycle P, no request to b is accepted before cycle P+1+cfg_trp.
- R9: A write with auto-precharge closes its bank internally in the same cycle that the earliest explicit precharge would be accepted. The bank is blocked until then, so the next access to that bank is accepted in the same cycle on both paths.
- R10: The command bus carries a command only in the cycle after an acceptance. A stalled request produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_twtr | input | TW | Write-to-read turnaround, cycles |
| cfg_twr | input | TW | Write recovery before precharge, cycles |
| cfg_trp | input | TW | Row precharge time, cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | 0 write, 1 read, 2 precharge, 3 no-op |
| req_bank | input | log2(NBANK) | Target bank |
| req_col | input | COLW | Starting column |
| req_bl | input | 2 | Burst-length code |
| req_ap | input | 1 | Auto-precharge on a write |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | Issued op code |
| cmd_bank | output | log2(NBANK) | Issued bank |
| cmd_col | output | COLW | Issued column |
| cmd_ap | output | 1 | Issued auto-precharge flag |
| wr_pair_valid | output | 1 | A write data pair is due this cycle |
| wr_pair_bank | output | log2(NBANK) | Bank of that pair |
| wr_pair_col | output | COLW | Column of that pair |

## Verification
The hardest case to reach from the ports is an auto-precharge write that is cut short by a write to another bank. In that case the recovery count starts from the truncation cycle, not from the natural end of the burst. Random traffic mixes writes to all banks with a one-in-five auto-precharge rate and frequent back-to-back issue, so armed banks are often truncated. A port-level model then bounds every later command to that bank. A directed pair of runs compares the auto and explicit paths cycle by cycle.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_RD  = 2'd1,
    OP_PRE = 2'd2,
    OP_NOP = 2'd3
  } wseq_op_e;

  localparam int unsigned PAIR_W = 3;
  localparam int unsigned IDX_W  = 2;

  // data pairs per burst for a burst-length code
  function automatic logic [PAIR_W-1:0] bl_pairs(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/wseq_dcnt.sv
module wseq_dcnt #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? val : (cnt_q - TW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - TW'(1)));

endmodule

// File: rtl/wseq_pair_sched.sv
module wseq_pair_sched
  import wseq_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int COLW  = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_acc,
  input  logic [$clog2(NBANK)-1:0] wr_bank,
  input  logic [COLW-1:0]          wr_col,
  input  logic [1:0]               wr_bl,
  output logic                     pend_valid,
  output logic                     last_pair,
  output logic [NBANK-1:0]         busy,
  output logic                     pair_valid,
  output logic [$clog2(NBANK)-1:0] pair_bank,
  output logic [COLW-1:0]          pair_col
);

  localparam int BW = $clog2(NBANK);

  // command stage: the write sits here for the cycle its command is on the bus
  logic              pend_q;
  logic [BW-1:0]     pbank_q;
  logic [COLW-1:0]   pcol_q;
  logic [PAIR_W-1:0] pn_q;

  // data stage
  logic [PAIR_W-1:0] rem_q, rem_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [BW-1:0]     bank_q;
  logic [COLW-1:0]   col_q;
  logic [PAIR_W-1:0] n_q;
  logic              run_en;

  always_comb begin
    run_en = pend_q || (rem_q != '0);
    rem_d  = rem_q;
    idx_d  = idx_q;
    if (pend_q) begin
      rem_d = pn_q;
      idx_d = '0;
    end else if (rem_q != '0) begin
      rem_d = rem_q - PAIR_W'(1);
      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rem_q  <= '0;
      idx_q  <= '0;
    end else begin
      pend_q <= wr_acc;
      if (run_en) begin
        rem_q <= rem_d;
        idx_q <= idx_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbank_q <= '0;
      pcol_q  <= '0;
      pn_q    <= '0;
    end else if (wr_acc) begin
      pbank_q <= wr_bank;
      pcol_q  <= wr_col;
      pn_q    <= bl_pairs(wr_bl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      col_q  <= '0;
      n_q    <= '0;
    end else if (pend_q) begin
      bank_q <= pbank_q;
      col_q  <= pcol_q;
      n_q    <= pn_q;
    end
  end

  // column of the current pair, wrapping inside the burst-aligned block
  logic [COLW-1:0] span, mask, offs;
  always_comb begin
    span     = COLW'(n_q) << 1;
    mask     = span - COLW'(1);
    offs     = COLW'(idx_q) << 1;
    pair_col = (col_q & ~mask) | ((col_q + offs) & mask);
  end

  assign pend_valid = pend_q;
  assign pair_valid = (rem_q != '0);
  assign pair_bank  = bank_q;
  assign last_pair  = pair_valid && ((rem_q == PAIR_W'(1)) || pend_q);

  for (genvar b = 0; b < NBANK; b++) begin : g_busy
    assign busy[b] = (pend_q && (pbank_q == BW'(b))) ||
                     (pair_valid && (bank_q == BW'(b)));
  end

  p_first_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> pair_valid);

  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= PAIR_W'(4));

  p_cut_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> (idx_q == '0));

endmodule

// File: rtl/wseq_bank.sv
module wseq_bank #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_twr,
  input  logic [TW-1:0] cfg_trp,
  input  logic          data_busy,
  input  logic          last_pair,
  input  logic          arm_ap,
  input  logic          pre_acc,
  input  logic          any_acc,
  output logic          rdy_cmd,
  output logic          rdy_pre
);

  logic ap_arm_q, ap_arm_d;
  logic ap_fire;
  logic wr_zero, rp_zero;
  logic rp_load;

  wseq_dcnt #(.TW(TW)) u_wr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (last_pair),
    .val  (cfg_twr),
    .zero (wr_zero)
  );

  wseq_dcnt #(.TW(TW)) u_rp (
    .clk  (clk),
    .rst_n(rst_n),
    .load (rp_load),
    .val  (cfg_trp),
    .zero (rp_zero)
  );

  always_comb begin
    ap_fire  = ap_arm_q && !data_busy && wr_zero;
    rp_load  = pre_acc || ap_fire;
    ap_arm_d = ap_arm_q;
    if (arm_ap) begin
      ap_arm_d = 1'b1;
    end else if (ap_fire) begin
      ap_arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_arm_q <= 1'b0;
    end else begin
      ap_arm_q <= ap_arm_d;
    end
  end

  assign rdy_cmd = rp_zero && !ap_arm_q;
  assign rdy_pre = rdy_cmd && !data_busy && wr_zero;

  p_rp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_zero |-> !any_acc);

  p_pre_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_acc |-> !data_busy);

  p_ap_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ap_arm_q) |-> $past(!data_busy && wr_zero));

  p_ap_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ap_arm_q |-> !any_acc);

endmodule

// File: rtl/wrburst_seq.sv
module wrburst_seq
  import wseq_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int COLW  = 10,
  parameter int TW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TW-1:0]            cfg_twtr,
  input  logic [TW-1:0]            cfg_twr,
  input  logic [TW-1:0]            cfg_trp,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [1:0]               req_op,
  input  logic [$clog2(NBANK)-1:0] req_bank,
  input  logic [COLW-1:0]          req_col,
  input  logic [1:0]               req_bl,
  input  logic                     req_ap,
  output logic                     cmd_valid,
  output logic [1:0]               cmd_op,
  output logic [$clog2(NBANK)-1:0] cmd_bank,
  output logic [COLW-1:0]          cmd_col,
  output logic                     cmd_ap,
  output logic                     wr_pair_valid,
  output logic [$clog2(NBANK)-1:0] wr_pair_bank,
  output logic [COLW-1:0]          wr_pair_col
);

  localparam int BW = $clog2(NBANK);

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_s1, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_i_n = rst_s1;

  wseq_op_e op;
  assign op = wseq_op_e'(req_op);

  logic [NBANK-1:0] rdy_cmd, rdy_pre, busy, lp_vec, arm_vec, pre_vec, acc_vec;
  logic pend_valid, last_pair, wtr_zero, rd_ok, acc, wr_acc;

  always_comb begin
    rd_ok = !pend_valid && !wr_pair_valid && wtr_zero;
    case (op)
      OP_WR:   req_ready = rdy_cmd[req_bank];
      OP_RD:   req_ready = rdy_cmd[req_bank] && rd_ok;
      OP_PRE:  req_ready = rdy_pre[req_bank];
      default: req_ready = 1'b1;
    endcase
    acc    = req_valid && req_ready;
    wr_acc = acc && (op == OP_WR);
  end

  wseq_pair_sched #(.NBANK(NBANK), .COLW(COLW)) u_sched (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_acc    (wr_acc),
    .wr_bank   (req_bank),
    .wr_col    (req_col),
    .wr_bl     (req_bl),
    .pend_valid(pend_valid),
    .last_pair (last_pair),
    .busy      (busy),
    .pair_valid(wr_pair_valid),
    .pair_bank (wr_pair_bank),
    .pair_col  (wr_pair_col)
  );

  wseq_dcnt #(.TW(TW)) u_wtr (
    .clk  (clk),
    .rst_n(rst_i_n),
    .load (last_pair),
    .val  (cfg_twtr),
    .zero (wtr_zero)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign acc_vec[b] = acc && (op != OP_NOP) && (req_bank == BW'(b));
    assign arm_vec[b] = acc_vec[b] && (op == OP_WR) && req_ap;
    assign pre_vec[b] = acc_vec[b] && (op == OP_PRE);
    assign lp_vec[b]  = last_pair && (wr_pair_bank == BW'(b));

    wseq_bank #(.TW(TW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .cfg_twr  (cfg_twr),
      .cfg_trp  (cfg_trp),
      .data_busy(busy[b]),
      .last_pair(lp_vec[b]),
      .arm_ap   (arm_vec[b]),
      .pre_acc  (pre_vec[b]),
      .any_acc  (acc_vec[b]),
      .rdy_cmd  (rdy_cmd[b]),
      .rdy_pre  (rdy_pre[b])
    );
  end

  // command bus
  logic cmd_valid_d;
  assign cmd_valid_d = acc && (op != OP_NOP);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= cmd_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cmd_op   <= '0;
      cmd_bank <= '0;
      cmd_col  <= '0;
      cmd_ap   <= 1'b0;
    end else if (cmd_valid_d) begin
      cmd_op   <= req_op;
      cmd_bank <= req_bank;
      cmd_col  <= req_col;
      cmd_ap   <= req_ap && (op == OP_WR);
    end
  end

  p_cmd_next_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_ready && (req_op != 2'd3)) |=> cmd_valid);

  p_no_stray_cmd_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmd_valid |-> $past(req_valid && req_ready));

  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_valid && (cmd_op == 2'd1)) |-> $past(!wr_pair_valid));

  p_wr_data_follows_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmd_valid && (cmd_op == 2'd0)) |=> wr_pair_valid);

endmodule

// File: tb/tb_wrburst_seq.sv
module tb_wrburst_seq;

  localparam int NBANK = 4;
  localparam int COLW  = 10;
  localparam int TW    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [TW-1:0] cfg_twtr, cfg_twr, cfg_trp;
  logic req_valid, req_ready, req_ap;
  logic [1:0] req_op, req_bl;
  logic [1:0] req_bank;
  logic [COLW-1:0] req_col;
  logic cmd_valid, cmd_ap;
  logic [1:0] cmd_op, cmd_bank;
  logic [COLW-1:0] cmd_col;
  logic wr_pair_valid;
  logic [1:0] wr_pair_bank;
  logic [COLW-1:0] wr_pair_col;

  wrburst_seq #(.NBANK(NBANK), .COLW(COLW), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_bank(req_bank), .req_col(req_col), .req_bl(req_bl), .req_ap(req_ap),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .wr_pair_valid(wr_pair_valid), .wr_pair_bank(wr_pair_bank),
    .wr_pair_col(wr_pair_col)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int npairs(input int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 4;
  endfunction

  function automatic int exp_col(input int start, input int n, input int k);
    int span = 2 * n;
    return ((start & ~(span - 1)) | ((start + 2 * k) & (span - 1))) & ((1 << COLW) - 1);
  endfunction

  // expected command, set by the driver at acceptance
  int exp_cmd_cyc = -1;
  int e_op, e_bank, e_col, e_ap;

  // port-level model used by the monitor
  bit mon_on = 1'b0;
  int m_rem, m_idx, m_n, m_bank, m_col;
  int last_any;
  int lastb [NBANK];
  int rp_until [NBANK];
  bit ap_arm [NBANK];
  bit prev_pv, prev_wr;
  int prev_pb, prev_wb;

  always @(negedge clk) begin
    if (mon_on) begin
      bit exp_pv;
      bit cmd_wr;
      exp_pv = (m_rem != 0);
      cmd_wr = cmd_valid && (cmd_op == 2'd0);
      if (wr_pair_valid || exp_pv) begin
        chk(wr_pair_valid == exp_pv, "R3/R5 pair valid", int'(wr_pair_valid), int'(exp_pv));
        if (exp_pv && wr_pair_valid) begin
          chk(int'(wr_pair_bank) == m_bank, "R3 pair bank", int'(wr_pair_bank), m_bank);
          chk(int'(wr_pair_col) == exp_col(m_col, m_n, m_idx), "R4 pair column",
              int'(wr_pair_col), exp_col(m_col, m_n, m_idx));
        end
      end
      if (cmd_valid || exp_cmd_cyc == cyc) begin
        chk(cmd_valid == (exp_cmd_cyc == cyc), "R10 command only after accept",
            int'(cmd_valid), int'(exp_cmd_cyc == cyc));
        if (cmd_valid && exp_cmd_cyc == cyc) begin
          chk(int'(cmd_op) == e_op && int'(cmd_bank) == e_bank, "R2 command op/bank",
              int'(cmd_op) * 16 + int'(cmd_bank), e_op * 16 + e_bank);
          chk(int'(cmd_col) == e_col && int'(cmd_ap) == e_ap, "R2 command col/ap",
              int'(cmd_col), e_col);
        end
      end
      if (cmd_valid) begin
        int b;
        b = int'(cmd_bank);
        chk(cyc >= rp_until[b], "R8/R9 bank closed", cyc, rp_until[b]);
        chk(!ap_arm[b], "R9 auto-precharge pending", int'(ap_arm[b]), 0);
        if (cmd_op == 2'd1) begin
          chk(!prev_pv && !prev_wr, "R6 read during write data", int'(prev_pv), 0);
          chk(cyc >= last_any + int'(cfg_twtr) + 2, "R6 read turnaround", cyc,
              last_any + int'(cfg_twtr) + 2);
        end
        if (cmd_op == 2'd2) begin
          chk(!(prev_pv && prev_pb == b) && !(prev_wr && prev_wb == b),
              "R7 precharge during own data", b, -1);
          chk(cyc >= lastb[b] + int'(cfg_twr) + 2, "R7 write recovery", cyc,
              lastb[b] + int'(cfg_twr) + 2);
          rp_until[b] = cyc + int'(cfg_trp) + 1;
        end
      end
      if (exp_pv && (m_rem == 1 || cmd_wr)) begin
        last_any = cyc;
        lastb[m_bank] = cyc;
        if (ap_arm[m_bank]) begin
          ap_arm[m_bank] = 1'b0;
          rp_until[m_bank] = cyc + int'(cfg_twr) + int'(cfg_trp) + 3;
        end
      end
      prev_pv = wr_pair_valid;
      prev_pb = int'(wr_pair_bank);
      prev_wr = cmd_wr;
      prev_wb = int'(cmd_bank);
      if (cmd_wr) begin
        m_n = npairs(e_bl_of_cmd);
        m_rem = m_n;
        m_idx = 0;
        m_bank = int'(cmd_bank);
        m_col = int'(cmd_col);
        if (cmd_ap) ap_arm[int'(cmd_bank)] = 1'b1;
      end else if (m_rem != 0) begin
        m_rem--;
        m_idx++;
      end
    end
  end

  // burst code of the command on the bus, kept by the driver
  int e_bl_of_cmd = 0;

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic do_req(input int op, input int b, input int col, input int bl,
                        input int ap, output int acc);
    req_valid = 1'b1;
    req_op = 2'(op);
    req_bank = 2'(b);
    req_col = COLW'(col);
    req_bl = 2'(bl);
    req_ap = 1'(ap);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc;
    if (op != 3) begin
      exp_cmd_cyc = cyc + 1;
      e_op = op;
      e_bank = b;
      e_col = col;
      e_ap = (op == 0) ? ap : 0;
      e_bl_of_cmd = bl;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t, t2, p, w, r, wa, we, cnt;
    void'($urandom(32'h1d5e_ed01));
    rst_n = 1'b0;
    req_valid = 1'b0; req_op = '0; req_bank = '0; req_col = '0; req_bl = '0; req_ap = 1'b0;
    cfg_twtr = 4'd2; cfg_twr = 4'd3; cfg_trp = 4'd2;
    m_rem = 0; m_idx = 0; m_n = 1; m_bank = 0; m_col = 0; last_any = -1000;
    prev_pv = 0; prev_wr = 0; prev_pb = 0; prev_wb = 0;
    for (int b = 0; b < NBANK; b++) begin
      lastb[b] = -1000; rp_until[b] = 0; ap_arm[b] = 1'b0;
    end
    idle(5);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R1: reset state
    chk(!cmd_valid, "R1 command idle", int'(cmd_valid), 0);
    chk(!wr_pair_valid, "R1 pairs idle", int'(wr_pair_valid), 0);
    for (int b = 0; b < NBANK; b++) begin
      for (int o = 0; o < 3; o++) begin
        req_op = 2'(o); req_bank = 2'(b);
        #1;
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
      end
    end
    idle(1);

    // R6: read right after a BL4 write
    do_req(0, 0, 6, 1, 0, t);
    do_req(1, 1, 0, 0, 0, r);
    chk(r == t + 4 + 2, "R6 read accept cycle", r - t, 6);
    idle(10);

    // R7/R8: precharge after a single-pair write, then reopen
    do_req(0, 3, 9, 0, 0, t);
    do_req(2, 3, 0, 0, 0, p);
    chk(p == t + 3 + 3, "R7 precharge accept cycle", p - t, 6);
    do_req(0, 3, 0, 0, 0, w);
    chk(w == p + 1 + 2, "R8 reopen cycle", w - p, 3);
    idle(10);

    // R7: precharge to another bank is not held by write data
    do_req(0, 0, 0, 2, 0, t);
    do_req(2, 2, 0, 0, 0, p);
    chk(p == t + 1, "R7 other bank precharge", p - t, 1);
    idle(10);

    // R5: truncation
    do_req(0, 1, 0, 2, 0, t);
    do_req(0, 2, 4, 0, 0, t2);
    chk(t2 == t + 1, "R5 back-to-back write accepted", t2 - t, 1);
    chk(wr_pair_valid && wr_pair_bank == 2'd1, "R5 single pair before cut",
        int'(wr_pair_bank), 1);
    idle(1);
    chk(wr_pair_valid && wr_pair_bank == 2'd2, "R5 new burst follows",
        int'(wr_pair_bank), 2);
    idle(1);
    chk(!wr_pair_valid, "R5 stream ends", int'(wr_pair_valid), 0);
    idle(10);

    // R5: concatenation without a gap
    do_req(0, 1, 2, 1, 0, t);
    idle(1);
    do_req(0, 2, 8, 1, 0, t2);
    chk(wr_pair_valid && wr_pair_bank == 2'd1, "R5 concat first burst", int'(wr_pair_bank), 1);
    idle(1);
    chk(wr_pair_valid && wr_pair_bank == 2'd2, "R5 concat second burst a", int'(wr_pair_bank), 2);
    idle(1);
    chk(wr_pair_valid && wr_pair_bank == 2'd2, "R5 concat second burst b", int'(wr_pair_bank), 2);
    idle(1);
    chk(!wr_pair_valid, "R5 concat end", int'(wr_pair_valid), 0);
    idle(10);

    // R9: auto-precharge against earliest explicit precharge
    do_req(0, 1, 0, 1, 1, t);
    do_req(0, 1, 0, 0, 0, w);
    wa = w - t;
    idle(10);
    do_req(0, 1, 0, 1, 0, t);
    do_req(2, 1, 0, 0, 0, p);
    do_req(0, 1, 0, 0, 0, w);
    we = w - t;
    chk(wa == we, "R9 auto equals explicit", wa, we);
    chk(wa == 5 + 3 + 2, "R9 auto reopen cycle", wa, 10);
    idle(10);

    // R2: op code 3 issues nothing
    do_req(3, 0, 5, 0, 0, t);
    chk(!cmd_valid, "R2 no-op silent", int'(cmd_valid), 0);
    idle(5);

    // R3: burst code 3 gives four pairs
    do_req(0, 0, 0, 3, 0, t);
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      idle(1);
      if (wr_pair_valid) cnt++;
    end
    chk(cnt == 4, "R3 code 3 pair count", cnt, 4);
    idle(5);

    // random traffic
    for (int i = 0; i < 2400; i++) begin
      int o, sel;
      if (i % 400 == 0) begin
        idle(40);
        cfg_twtr = TW'($urandom % 6);
        cfg_twr = TW'($urandom % 6);
        cfg_trp = TW'($urandom % 6);
      end
      sel = $urandom % 8;
      o = (sel < 4) ? 0 : (sel < 6) ? 1 : (sel == 6) ? 2 : 3;
      do_req(o, $urandom % NBANK, $urandom % 1024, $urandom % 4,
             ($urandom % 5 == 0) ? 1 : 0, t);
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
    end
    idle(40);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule